// File: doc/BRIEF.md
# DRAM Power-Up and Idle Re-Wake Sequencer

This block sits between a memory controller and an asynchronous DRAM array and owns the row (RAS) and column (CAS) strobes. After reset it keeps both strobes inactive through a settling pause. The pause length is a cycle count derived from the clock frequency. It then runs a fixed number of wake-up refresh cycles, either RAS-only or CAS-before-RAS as selected per cycle, and only then raises its ready flag.

Once ready, the block turns each controller request into one access strobe cycle and pulses a grant as it starts that cycle. Requests that arrive while the block is not ready are counted and served one after another once it is ready. An idle monitor watches the row strobe. If the strobe has not fallen for the idle threshold, the block drops ready and repeats the whole wake-up burst before it grants anything more.

Top module: `dinit_seq`

## Requirements
- R1: While reset is asserted, and for the two reset-synchronizer cycles after it is released, ras_n=1, cas_n=1, ready=0 and acc_gnt=0.
- R2: For the first PAUSE_CYC = CLK_MHZ*PAUSE_US cycles after internal reset release, both strobes stay high, ready=0 and acc_gnt=0.
- R3: After the pause, exactly INIT_CNT wake cycles (INIT_CNT RAS falling edges) take place before ready rises. Ready rises in the cycle after the last wake cycle ends.
- R4: rfsh_sel is sampled when a wake cycle starts. With rfsh_sel=1 the cycle is CAS-before-RAS: CAS is low alone for 1 cycle, then both are low for RAS_LOW_CYC cycles, then both are high for PRE_CYC cycles. With rfsh_sel=0 the cycle is RAS-only: RAS is low for RAS_LOW_CYC cycles with CAS high, then RAS is high for PRE_CYC cycles. At least one idle cycle follows every strobe cycle.
- R5: Whenever CAS returns high, RAS returns high in the same cycle.
- R6: An idle counter clears on each RAS falling edge and saturates at IDLE_CYC = CLK_MHZ*IDLE_MS*1000. When it is saturated while ready=1 and no strobe cycle is running, ready drops in the next cycle and INIT_CNT wake cycles run again.
- R7: No grant is issued while the idle counter is saturated. A request pending at that moment is granted only after the repeated wake burst completes.
- R8: While ready=1, no strobe cycle is running and a request is pending, acc_gnt pulses for one cycle. During the next RAS_LOW_CYC cycles RAS is low, and CAS is low from the second of those cycles. Both then rise together and stay high for PRE_CYC cycles.
- R9: Pending requests are counted up to PEND_MAX; further requests while full are dropped. Each grant consumes one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | One request per cycle it is high |
| rfsh_sel | input | 1 | Wake cycle type: 1 CAS-before-RAS, 0 RAS-only |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ready | output | 1 | High when accesses may be granted |
| acc_gnt | output | 1 | One-cycle pulse when an access cycle starts |

## Verification
Idle-threshold expiry and the grant of a pending request can fall in the same cycle. In that case re-waking must win. The bench provokes this by using its reference model's idle count to place a request in the cycle before the counter saturates, so the request is pending exactly when expiry is seen. It judges the outcome by requiring that ready falls and a full wake burst runs before that request's grant appears, and by comparing every output against the model in every cycle.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  typedef enum logic [1:0] {
    CYC_ROR = 2'd0,
    CYC_CBR = 2'd1,
    CYC_ACC = 2'd2
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } seq_st_e;

endpackage

// File: rtl/dinit_rst_sync.sv
module dinit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/dinit_strobe_gen.sv
module dinit_strobe_gen
  import dinit_pkg::*;
#(
  parameter int unsigned RAS_LOW_CYC = 3,
  parameter int unsigned PRE_CYC     = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  cyc_kind_e kind_i,
  output logic      active,
  output logic      ras_n,
  output logic      cas_n
);

  localparam int unsigned LEN_LONG = 1 + RAS_LOW_CYC + PRE_CYC;
  localparam int unsigned STEP_W   = $clog2(LEN_LONG + 1);
  localparam logic [STEP_W-1:0] RL_S      = STEP_W'(RAS_LOW_CYC);
  localparam logic [STEP_W-1:0] LAST_LONG = STEP_W'(LEN_LONG - 1);
  localparam logic [STEP_W-1:0] LAST_STD  = STEP_W'(LEN_LONG - 2);

  logic              act_q, act_d;
  cyc_kind_e         kind_q, kind_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              ras_low_d, cas_low_d;
  logic              ras_n_q, cas_n_q;
  logic              at_end;

  // Strobe levels for a given step of a given cycle kind.
  function automatic logic [1:0] lows(input logic a, input cyc_kind_e k,
                                      input logic [STEP_W-1:0] s);
    logic r, c;
    r = 1'b0;
    c = 1'b0;
    if (a) begin
      case (k)
        CYC_CBR: begin
          c = (s <= RL_S);
          r = (s >= STEP_W'(1)) && (s <= RL_S);
        end
        CYC_ACC: begin
          r = (s < RL_S);
          c = (s >= STEP_W'(1)) && (s < RL_S);
        end
        default: begin
          r = (s < RL_S);
          c = 1'b0;
        end
      endcase
    end
    return {r, c};
  endfunction

  assign at_end = act_q && (step_q == ((kind_q == CYC_CBR) ? LAST_LONG : LAST_STD));

  always_comb begin
    act_d  = act_q;
    kind_d = kind_q;
    step_d = step_q;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        kind_d = kind_i;
        step_d = '0;
      end
    end else if (at_end) begin
      act_d = 1'b0;
    end else begin
      step_d = step_q + STEP_W'(1);
    end
    {ras_low_d, cas_low_d} = lows(act_d, kind_d, step_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      kind_q  <= CYC_ROR;
      step_q  <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
    end else begin
      act_q   <= act_d;
      kind_q  <= kind_d;
      step_q  <= step_d;
      ras_n_q <= ~ras_low_d;
      cas_n_q <= ~cas_low_d;
    end
  end

  assign active = act_q;
  assign ras_n  = ras_n_q;
  assign cas_n  = cas_n_q;

endmodule

// File: rtl/dinit_idle_mon.sv
module dinit_idle_mon #(
  parameter int unsigned IDLE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  output logic expired
);

  localparam int unsigned CNT_W = $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYC);

  logic             ras_prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ras_fall;
  logic             cnt_en;

  assign ras_fall = ras_prev_q && !ras_n;
  assign cnt_en   = ras_fall || (cnt_q != LIMIT);

  always_comb begin
    if (ras_fall) cnt_d = '0;
    else          cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev_q <= 1'b1;
      cnt_q      <= '0;
    end else begin
      ras_prev_q <= ras_n;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == LIMIT);

endmodule

// File: rtl/dinit_pend_cnt.sv
module dinit_pend_cnt #(
  parameter int unsigned PEND_MAX = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  output logic nonzero
);

  localparam int unsigned PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = req ^ take;

  always_comb begin
    cnt_d = cnt_q;
    if (take && !req)                 cnt_d = cnt_q - PW'(1);
    else if (req && !take && cnt_q != FULL) cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign nonzero = (cnt_q != '0);

endmodule

// File: rtl/dinit_seq.sv
module dinit_seq
  import dinit_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned PAUSE_US    = 500,
  parameter int unsigned IDLE_MS     = 64,
  parameter int unsigned INIT_CNT    = 8,
  parameter int unsigned RAS_LOW_CYC = 3,
  parameter int unsigned PRE_CYC     = 2,
  parameter int unsigned PEND_MAX    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic rfsh_sel,
  output logic ras_n,
  output logic cas_n,
  output logic ready,
  output logic acc_gnt
);

  localparam int unsigned PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int unsigned IDLE_CYC  = CLK_MHZ * IDLE_MS * 1000;
  localparam int unsigned PAUSE_W   = $clog2(PAUSE_CYC);
  localparam int unsigned WAKE_W    = $clog2(INIT_CNT + 1);
  localparam logic [PAUSE_W-1:0] PAUSE_LAST = PAUSE_W'(PAUSE_CYC - 1);
  localparam logic [WAKE_W-1:0]  WAKE_ALL   = WAKE_W'(INIT_CNT);

  logic               rst_sync_n;
  seq_st_e            state_q, state_d;
  logic [PAUSE_W-1:0] pause_q, pause_d;
  logic [WAKE_W-1:0]  wake_q, wake_d;
  logic               pause_en, wake_en;
  logic               gen_start, gen_act;
  cyc_kind_e          gen_kind;
  logic               idle_exp;
  logic               pend_nz;
  logic               gnt;

  dinit_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dinit_strobe_gen #(
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .PRE_CYC     (PRE_CYC)
  ) u_gen (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (gen_start),
    .kind_i (gen_kind),
    .active (gen_act),
    .ras_n  (ras_n),
    .cas_n  (cas_n)
  );

  dinit_idle_mon #(
    .IDLE_CYC (IDLE_CYC)
  ) u_idle (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ras_n   (ras_n),
    .expired (idle_exp)
  );

  dinit_pend_cnt #(
    .PEND_MAX (PEND_MAX)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (acc_req),
    .take    (gnt),
    .nonzero (pend_nz)
  );

  // Next-state logic: pause, wake burst, run with idle re-wake.
  always_comb begin
    state_d   = state_q;
    pause_d   = pause_q;
    wake_d    = wake_q;
    gen_start = 1'b0;
    gen_kind  = CYC_ROR;
    gnt       = 1'b0;
    case (state_q)
      ST_PAUSE: begin
        if (pause_q == PAUSE_LAST) begin
          state_d = ST_WAKE;
          wake_d  = '0;
        end else begin
          pause_d = pause_q + PAUSE_W'(1);
        end
      end
      ST_WAKE: begin
        if (!gen_act) begin
          if (wake_q != WAKE_ALL) begin
            gen_start = 1'b1;
            gen_kind  = rfsh_sel ? CYC_CBR : CYC_ROR;
            wake_d    = wake_q + WAKE_W'(1);
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (!gen_act) begin
          if (idle_exp) begin
            state_d = ST_WAKE;
            wake_d  = '0;
          end else if (pend_nz) begin
            gen_start = 1'b1;
            gen_kind  = CYC_ACC;
            gnt       = 1'b1;
          end
        end
      end
      default: state_d = ST_PAUSE;
    endcase
  end

  assign pause_en = (state_q == ST_PAUSE);
  assign wake_en  = (wake_d != wake_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_PAUSE;
      pause_q <= '0;
      wake_q  <= '0;
    end else begin
      state_q <= state_d;
      if (pause_en) pause_q <= pause_d;
      if (wake_en)  wake_q  <= wake_d;
    end
  end

  assign ready   = (state_q == ST_RUN);
  assign acc_gnt = gnt;

endmodule

// File: rtl/dinit_seq_chk.sv
module dinit_seq_chk
  import dinit_pkg::*;
#(
  parameter int unsigned INIT_CNT = 8,
  parameter int unsigned WAKE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              ready,
  input logic              acc_gnt,
  input seq_st_e           state_q,
  input logic [WAKE_W-1:0] wake_q,
  input logic              idle_exp
);

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAUSE) |-> (ras_n && cas_n && !ready && !acc_gnt)); // R2

  AST_READY_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (wake_q == WAKE_W'(INIT_CNT))); // R3

  AST_CBR_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> !$past(cas_n)); // R4

  AST_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n)); // R5

  AST_NO_GNT_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> !idle_exp); // R7

  AST_GNT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (ready && ras_n && cas_n)); // R8

  AST_GNT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |=> !acc_gnt); // R8

endmodule

bind dinit_seq dinit_seq_chk #(
  .INIT_CNT (INIT_CNT),
  .WAKE_W   (WAKE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .ready    (ready),
  .acc_gnt  (acc_gnt),
  .state_q  (state_q),
  .wake_q   (wake_q),
  .idle_exp (idle_exp)
);

// File: tb/dinit_seq_tb_top.sv
module dinit_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 1;
  localparam int PAUSE_US   = 40;
  localparam int IDLE_MS    = 1;
  localparam int INIT_CNT   = 8;
  localparam int RL         = 3;
  localparam int PRE        = 2;
  localparam int PEND_MAX   = 7;
  localparam int PAUSE_CYC  = CLK_MHZ * PAUSE_US;
  localparam int IDLE_CYC   = CLK_MHZ * IDLE_MS * 1000;
  localparam int WATCHDOG   = 100000;

  logic clk;
  logic rst_n;
  logic acc_req;
  logic rfsh_sel;
  logic ras_n, cas_n, ready, acc_gnt;

  dinit_seq #(
    .CLK_MHZ (CLK_MHZ), .PAUSE_US (PAUSE_US), .IDLE_MS (IDLE_MS),
    .INIT_CNT (INIT_CNT), .RAS_LOW_CYC (RL), .PRE_CYC (PRE), .PEND_MAX (PEND_MAX)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .acc_req (acc_req), .rfsh_sel (rfsh_sel),
    .ras_n (ras_n), .cas_n (cas_n), .ready (ready), .acc_gnt (acc_gnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp, n_bad;
  bit finished;

  task automatic chk(input bit ok, input string tag, input int act, input int exp,
                     input string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int m_sync, m_phase, m_tick, m_wk, m_pend, m_idle;
  bit m_prev_ras;
  bit qr[$];
  bit qc[$];

  function automatic bit m_ras(); return (qr.size() != 0) ? qr[0] : 1'b1; endfunction
  function automatic bit m_cas(); return (qc.size() != 0) ? qc[0] : 1'b1; endfunction
  function automatic bit m_exp(); return m_idle == IDLE_CYC; endfunction
  function automatic bit m_gnt();
    return (m_phase == 2) && (qr.size() == 0) && !m_exp() && (m_pend > 0);
  endfunction

  // kind: 0 RAS-only, 1 CAS-before-RAS, 2 access
  task automatic push_cycle(input int kind);
    if (kind == 1) begin qr.push_back(1); qc.push_back(0); end
    for (int i = 0; i < RL; i++) begin
      qr.push_back(0);
      qc.push_back((kind == 1) || (kind == 2 && i > 0) ? 1'b0 : 1'b1);
    end
    for (int i = 0; i < PRE; i++) begin qr.push_back(1); qc.push_back(1); end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_phase = 0; m_tick = 0; m_wk = 0; m_pend = 0; m_idle = 0;
      m_prev_ras = 1; qr.delete(); qc.delete();
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit cur, busy, ex, g;
      int sk;
      cur = m_ras(); busy = (qr.size() != 0); ex = m_exp(); g = m_gnt(); sk = -1;
      if (m_phase == 0) begin
        if (m_tick == PAUSE_CYC - 1) begin m_phase = 1; m_wk = 0; end
        else m_tick++;
      end else if (m_phase == 1) begin
        if (!busy) begin
          if (m_wk < INIT_CNT) begin sk = rfsh_sel ? 1 : 0; m_wk++; end
          else m_phase = 2;
        end
      end else begin
        if (!busy && ex) begin m_phase = 1; m_wk = 0; end
        else if (g) sk = 2;
      end
      if (busy) begin void'(qr.pop_front()); void'(qc.pop_front()); end
      if (sk >= 0) push_cycle(sk);
      if (m_prev_ras && !cur) m_idle = 0;
      else if (m_idle < IDLE_CYC) m_idle++;
      m_prev_ras = cur;
      m_pend = m_pend - int'(g) + int'(acc_req);
      if (m_pend > PEND_MAX) m_pend = PEND_MAX;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int  cyc, falls, n_gnt, ready_falls, n_cbr, n_ror;
  bit  p_ras, p_cas, p_rdy;
  bit  collide_armed, saw_rewake;

  always @(negedge clk) begin
    string t;
    cyc++;
    if (cyc > WATCHDOG) begin
      chk(1'b0, "R1", cyc, WATCHDOG, "watchdog expired");
      finish_run();
    end
    if (!rst_n) begin
      chk(ras_n && cas_n && !ready && !acc_gnt, "R1",
          {ras_n, cas_n, ready, acc_gnt}, 4'b1100, "reset outputs");
    end else if (!finished) begin
      t = (m_phase == 0) ? "R2" : (m_phase == 1) ? "R4" : "R8";
      chk(ras_n == m_ras(), t, ras_n, m_ras(), "ras_n");
      chk(cas_n == m_cas(), t, cas_n, m_cas(), "cas_n");
      chk(ready == (m_phase == 2), (m_phase == 2) ? "R6" : "R3", ready,
          int'(m_phase == 2), "ready");
      chk(acc_gnt == m_gnt(), "R8", acc_gnt, m_gnt(), "acc_gnt");
      if (p_ras && !ras_n) begin
        falls++;
        if (!ready && !cas_n) n_cbr++;
        if (!ready && cas_n) n_ror++;
      end
      if (!p_cas && cas_n)
        chk(!p_ras && ras_n, "R5", ras_n, 1, "ras_n rise with cas_n rise");
      if (!p_rdy && ready) begin
        chk(falls == INIT_CNT, "R3", falls, INIT_CNT, "wake cycles before ready");
        falls = 0;
      end
      if (p_rdy && !ready) begin
        ready_falls++; falls = 0;
        if (collide_armed) saw_rewake = 1;
      end
      if (acc_gnt) begin
        n_gnt++;
        if (collide_armed) begin
          chk(saw_rewake, "R7", saw_rewake, 1, "re-wake before colliding grant");
          collide_armed = 0;
        end
      end
      p_ras = ras_n; p_cas = cas_n; p_rdy = ready;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rfsh_sel = 1'b0;
    forever begin
      repeat (5) @(negedge clk);
      rfsh_sel = ~rfsh_sel;
    end
  end

  task automatic req_pulse();
    acc_req = 1'b1;
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; finished = 0; cyc = 0;
    falls = 0; n_gnt = 0; ready_falls = 0; n_cbr = 0; n_ror = 0;
    p_ras = 1; p_cas = 1; p_rdy = 0; collide_armed = 0; saw_rewake = 0;
    acc_req = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R9: nine requests during the pause, only PEND_MAX kept
    for (int i = 0; i < 9; i++) req_pulse();
    repeat (250) @(negedge clk);
    chk(n_gnt == PEND_MAX, "R9", n_gnt, PEND_MAX, "grants after saturated queue");
    chk(n_cbr > 0 && n_ror > 0, "R4", n_cbr * 100 + n_ror, 1, "mix of wake kinds");
    // R8: back-to-back and spaced requests while ready
    for (int i = 0; i < 3; i++) req_pulse();
    repeat (4) @(negedge clk);
    req_pulse();
    repeat (30) @(negedge clk);
    chk(n_gnt == PEND_MAX + 4, "R8", n_gnt, PEND_MAX + 4, "grants while ready");
    // R6/R7: request lands in the cycle before idle saturation
    while (!(m_phase == 2 && m_idle == IDLE_CYC - 1 && m_pend == 0 && qr.size() == 0))
      @(negedge clk);
    collide_armed = 1;
    req_pulse();
    repeat (150) @(negedge clk);
    chk(ready_falls >= 1, "R6", ready_falls, 1, "ready dropped on idle");
    chk(collide_armed == 0, "R7", collide_armed, 0, "colliding request granted");
    // R6: idle expiry with nothing pending
    repeat (IDLE_CYC + 150) @(negedge clk);
    chk(ready_falls >= 2, "R6", ready_falls, 2, "second idle re-wake");
    chk(ready == 1'b1, "R6", ready, 1, "ready after second re-wake");
    finish_run();
  end

endmodule